// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

This block is a register-mapped timer peripheral with four independent down-counters and one shared interrupt block. Software reaches it through a single-cycle, word-addressed register port with separate read and write strobes. Each channel holds a load value, a running count, a control word and a value kept aside for later reloads. The count decrements on ticks from a per-channel prescaler. When the count reaches zero, one of three things follows: it stops there, it reloads from the kept-aside value, or it rolls through its full range.

Each channel latches an event when its count reaches zero. The interrupt block keeps these events as raw status bits. Software can mask and clear them, and the masked bits are ORed onto one interrupt line. Either 16-bit or 32-bit counting is selected per channel.

Top module: `quad_down_timer`

## Requirements
- R1: The port address is a word index (byte offset / 4). Words 0..3 are the shared words: mask, raw status, masked status and clear. Channel n uses words 4+4n .. 7+4n, which hold in turn its load, current count, control and reload value. `bus_rdata` shows the addressed word in the cycle after `bus_rd`. Word 3 and the words 20 and above read as zero.
- R2: A write to a channel's load word sets its load word and its reload word to the written data. The same write sets the current count to the data masked to the active width. A write to the reload word changes nothing but the value used at the next reload.
- R3: Control bits [3:2] pick the prescale: 00 divides by 1, 01 by 16, and 10 or 11 by 256. An enabled channel decrements once on every prescaled tick. With divide-by-N, the first decrement comes on the N-th clock edge after the enabling write.
- R4: With control bit 1 at 0, the channel counts in 16 bits. Loads are truncated to 16 bits, the count rolls to 0xFFFF, and reads are zero-extended. With bit 1 at 1, the channel counts in 32 bits.
- R5: With control bit 0 at 0 and bit 6 at 0 (free-running), a tick at a count of zero gives the full-scale value: 0xFFFFFFFF, or 0xFFFF in 16-bit mode.
- R6: With control bit 0 at 0 and bit 6 at 1 (periodic), a tick at a count of zero reloads the count from the reload word.
- R7: With control bit 0 at 1 (one-shot), the count stays at zero once it gets there. Control bit 7 stays set.
- R8: A tick that moves channel n's count from 1 to 0 sets bit n of the raw status word.
- R9: Writing ones to the clear word clears the matching raw bits. A bit that is set by a new event in the same cycle stays set.
- R10: The mask word holds bits [3:0] and can be read and written. The masked status word equals raw AND mask. `irq_o` is the OR of the masked bits, and it follows them one clock later.
- R11: With control bit 7 at 0, the channel does not count. Reset clears every register, the prescalers and `irq_o`.
- R12: Writes to a current-count word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (5) | Word index of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Combined masked interrupt, registered |

## Verification
Read data is due one edge after the read strobe. A count or a status bit changes on the edge that samples its tick or its write, and `irq_o` follows the status one edge after that. The bench holds a behavioural model that advances on the same edges from the same sampled inputs. It records the expected read word at the strobe edge and compares it at the following falling edge. It compares `irq_o` with the model on every falling edge. Because of this, prescale phases of 16 and 256, reloads and clears that land in the same cycle, and writes that race a tick are all checked to the exact cycle.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int CTRL_W  = 8;
  localparam int SHR_NUM = 4;   // shared words before the channels
  localparam int CH_WORDS = 4;

  // shared word indices
  localparam int W_MASK  = 0;
  localparam int W_RAW   = 1;
  localparam int W_MSKD  = 2;
  localparam int W_CLR   = 3;

  // per-channel word offsets
  localparam int OFF_LOAD = 0;
  localparam int OFF_CUR  = 1;
  localparam int OFF_CTRL = 2;
  localparam int OFF_RLD  = 3;

  typedef struct packed {
    logic       en;        // bit 7
    logic       periodic;  // bit 6
    logic [1:0] spare;     // bits 5:4
    logic [1:0] presc;     // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;
endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler #(
  parameter int DIV_W    = 8,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick_o
);
  localparam logic [DIV_W-1:0] LIM_MID  = DIV_W'(DIV_MID - 1);
  localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'(DIV_SLOW - 1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;
  logic             at_lim;

  always_comb begin
    case (sel)
      2'b00:   limit = '0;
      2'b01:   limit = LIM_MID;
      default: limit = LIM_SLOW;
    endcase
  end

  assign at_lim = (cnt_q >= limit);
  assign tick_o = en && at_lim;

  always_ff @(posedge clk) begin
    if (rst || !en || at_lim) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R11: a disabled divider restarts from zero
  p_idle_restart_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int DIV_W    = 8,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              rld_we,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cur_o,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] rld_o,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] NARROW_MSK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q, cur_q, rld_q;
  logic [DATA_W-1:0] msk, cur_eff;
  logic              tick;

  assign msk     = ctrl_q.wide ? '1 : NARROW_MSK;
  assign cur_eff = cur_q & msk;

  qdt_prescaler #(
    .DIV_W(DIV_W), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_presc (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .sel(ctrl_q.presc), .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      cur_q  <= '0;
      rld_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (rld_we)  rld_q  <= wdata;
      if (ld_we) begin
        load_q <= wdata;
        rld_q  <= wdata;
        cur_q  <= wdata & msk;
      end else if (tick) begin
        if (cur_eff != '0)        cur_q <= (cur_eff - 1'b1) & msk;
        else if (!ctrl_q.oneshot) cur_q <= ctrl_q.periodic ? (rld_q & msk) : msk;
      end
    end
  end

  assign hit_o  = tick && !ld_we && (cur_eff == DATA_W'(1));
  assign load_o = load_q;
  assign cur_o  = cur_eff;
  assign ctrl_o = ctrl_q;
  assign rld_o  = rld_q;

  // R3: each tick removes exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && cur_eff != '0 && !ld_we && !ctrl_we) |=> (cur_eff == $past(cur_eff) - 1'b1));
  // R7: one-shot count parks at zero
  p_park_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.en && ctrl_q.oneshot && cur_eff == '0 && !ld_we && !ctrl_we) |=> (cur_eff == '0));
  // R5: free-running roll goes to full scale
  p_full_roll_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && cur_eff == '0 && !ctrl_q.oneshot && !ctrl_q.periodic && !ld_we && !ctrl_we)
      |=> (cur_eff == $past(msk)));
endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] raw_q, mask_q, clr_bits;
  logic              irq_q;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | hit;
      if (mask_we) mask_q <= wdata;
      irq_q <= |(raw_q & mask_q);
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R8: an event always lands in raw status
  p_event_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((raw_q & $past(hit)) == $past(hit)));
  // R9: cleared bits without a new event go low
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((raw_q & $past(wdata & ~hit)) == '0));
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
  import qdt_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int ADDR_W   = 5,
  parameter int DIV_W    = 8,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [31:0]       wi;
  logic [NUM_CH-1:0] hits, raw, mask;
  logic [DATA_W-1:0] ch_load [NUM_CH];
  logic [DATA_W-1:0] ch_cur  [NUM_CH];
  logic [DATA_W-1:0] ch_rld  [NUM_CH];
  ctrl_t             ch_ctrl [NUM_CH];
  logic [DATA_W-1:0] rd_val, rdata_q;

  assign wi = {{(32-ADDR_W){1'b0}}, bus_addr};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = SHR_NUM + CH_WORDS * g;
    qdt_channel #(
      .DATA_W(DATA_W), .NARROW_W(NARROW_W), .DIV_W(DIV_W),
      .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
    ) u_ch (
      .clk(clk), .rst(rst),
      .ld_we  (bus_wr && wi == 32'(BASE + OFF_LOAD)),
      .rld_we (bus_wr && wi == 32'(BASE + OFF_RLD)),
      .ctrl_we(bus_wr && wi == 32'(BASE + OFF_CTRL)),
      .wdata(bus_wdata),
      .load_o(ch_load[g]), .cur_o(ch_cur[g]), .ctrl_o(ch_ctrl[g]),
      .rld_o(ch_rld[g]), .hit_o(hits[g])
    );
  end

  qdt_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst), .hit(hits),
    .mask_we(bus_wr && wi == 32'(W_MASK)),
    .clr_we (bus_wr && wi == 32'(W_CLR)),
    .wdata(bus_wdata[NUM_CH-1:0]),
    .raw_o(raw), .mask_o(mask), .irq_o(irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (wi == 32'(W_MASK)) rd_val = DATA_W'(mask);
    if (wi == 32'(W_RAW))  rd_val = DATA_W'(raw);
    if (wi == 32'(W_MSKD)) rd_val = DATA_W'(raw & mask);
    for (int c = 0; c < NUM_CH; c++) begin
      if (wi == 32'(SHR_NUM + CH_WORDS*c + OFF_LOAD)) rd_val = ch_load[c];
      if (wi == 32'(SHR_NUM + CH_WORDS*c + OFF_CUR))  rd_val = ch_cur[c];
      if (wi == 32'(SHR_NUM + CH_WORDS*c + OFF_CTRL)) rd_val = DATA_W'(ch_ctrl[c]);
      if (wi == 32'(SHR_NUM + CH_WORDS*c + OFF_RLD))  rd_val = ch_rld[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;

  // R10: a masked raw bit raises the line one edge later
  p_line_follows_r10: assert property (@(posedge clk) disable iff (rst)
    ((raw & mask) != '0) |=> irq_o);
endmodule

// File: tb/quad_down_timer_bench.sv
module quad_down_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_down_timer u_quad_down_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference
  logic [31:0] m_load [4], m_cur [4], m_bg [4];
  logic [7:0]  m_ctrl [4];
  int          m_div [4];
  logic [3:0]  m_raw, m_mask, hits;
  logic        m_irq, nirq;
  logic [31:0] exp_rd;

  function automatic logic [31:0] mread(input int a);
    int c, k;
    logic [31:0] msk;
    if (a == 0) return {28'd0, m_mask};
    if (a == 1) return {28'd0, m_raw};
    if (a == 2) return {28'd0, m_raw & m_mask};
    if (a < 4 || a >= 20) return 32'd0;
    c = (a - 4) / 4;
    k = (a - 4) % 4;
    msk = m_ctrl[c][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    case (k)
      0: return m_load[c];
      1: return m_cur[c] & msk;
      2: return {24'd0, m_ctrl[c]};
      default: return m_bg[c];
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        m_load[c] = 0; m_cur[c] = 0; m_bg[c] = 0; m_ctrl[c] = 0; m_div[c] = 0;
      end
      m_raw = 0; m_mask = 0; m_irq = 0; exp_rd = 0;
    end else begin
      if (bus_rd) exp_rd = mread(int'(bus_addr));
      nirq = |(m_raw & m_mask);
      hits = 0;
      for (int c = 0; c < 4; c++) begin
        logic [31:0] msk, cv;
        int lim, base;
        bit tk;
        msk = m_ctrl[c][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        lim = (m_ctrl[c][3:2] == 0) ? 0 : (m_ctrl[c][3:2] == 1) ? 15 : 255;
        tk = m_ctrl[c][7] && (m_div[c] >= lim);
        if (!m_ctrl[c][7] || m_div[c] >= lim) m_div[c] = 0; else m_div[c]++;
        cv = m_cur[c] & msk;
        base = 4 + 4*c;
        if (bus_wr && bus_addr == base) begin
          m_load[c] = bus_wdata; m_bg[c] = bus_wdata; m_cur[c] = bus_wdata & msk;
        end else begin
          if (tk) begin
            if (cv != 0) begin
              m_cur[c] = cv - 1;
              if (cv == 1) hits[c] = 1'b1;
            end else if (!m_ctrl[c][0]) begin
              m_cur[c] = m_ctrl[c][6] ? (m_bg[c] & msk) : msk;
            end
          end
          if (bus_wr && bus_addr == base + 3) m_bg[c] = bus_wdata;
        end
        if (bus_wr && bus_addr == base + 2) m_ctrl[c] = bus_wdata[7:0];
      end
      if (bus_wr && bus_addr == 3) m_raw = m_raw & ~bus_wdata[3:0];
      m_raw = m_raw | hits;
      if (bus_wr && bus_addr == 0) m_mask = bus_wdata[3:0];
      m_irq = nirq;
    end
  end

  // R10: line compared every cycle
  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if (irq_o !== m_irq) begin
        fails++;
        $display("FAIL R10 irq_o actual %0b expected %0b at %0t", irq_o, m_irq, $time);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    tests++;
    if (bus_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s word %0d actual %08h expected %08h", req, a, bus_rdata, exp_rd);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    rd(0, "R11"); rd(1, "R11"); rd(5, "R11"); rd(6, "R11");
    // R1 / R2 / R12: map, load copies, current word is read-only
    wr(4, 32'd5);
    rd(4, "R1"); rd(5, "R2"); rd(7, "R2");
    wr(5, 32'd99);
    rd(5, "R12");
    rd(3, "R1"); rd(20, "R1"); rd(31, "R1");
    // R5 / R8: 32-bit free-running, divide by 1
    wr(6, 32'h82);
    rd(6, "R1");
    idle(3);
    rd(5, "R3");
    idle(4);
    rd(5, "R5"); rd(1, "R8");
    // R10 / R9
    rd(2, "R10");
    wr(0, 32'h1);
    rd(0, "R10"); rd(2, "R10");
    idle(2);
    wr(3, 32'h1);
    rd(1, "R9"); rd(2, "R9");
    // R6: periodic reload from separately written reload word
    wr(8, 32'd3);
    wr(11, 32'd6);
    rd(8, "R2"); rd(11, "R2"); rd(9, "R2");
    wr(10, 32'hC2);
    for (int i = 0; i < 8; i++) rd(9, "R6");
    rd(1, "R8");
    wr(0, 32'hF);
    // R7: one-shot
    wr(12, 32'd2);
    wr(14, 32'h83);
    idle(6);
    rd(13, "R7"); rd(14, "R7");
    idle(5);
    rd(13, "R7"); rd(1, "R8");
    // R9: clear everything while ch1 keeps firing
    for (int i = 0; i < 6; i++) begin
      wr(3, 32'hF);
      rd(1, "R9");
    end
    // R4: narrow mode
    wr(16, 32'h0001_2345);
    rd(17, "R4"); rd(16, "R4");
    wr(16, 32'd1);
    wr(18, 32'h80);
    idle(2);
    rd(17, "R4");
    idle(1);
    rd(17, "R4");
    // R3: divide by 16 and by 256
    wr(6, 32'h06);
    wr(4, 32'd3);
    wr(6, 32'h86);
    idle(10);
    rd(5, "R3");
    idle(30);
    rd(5, "R3");
    wr(6, 32'h0A);
    wr(4, 32'd2);
    wr(6, 32'h8A);
    idle(250);
    rd(5, "R3");
    idle(300);
    rd(5, "R3");
    wr(6, 32'h8E);
    idle(260);
    rd(5, "R3");
    // R11: disabled channel holds
    wr(10, 32'h42);
    rd(9, "R11");
    idle(20);
    rd(9, "R11"); rd(10, "R11");
    wr(3, 32'hF);
    rd(1, "R9");
    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule